// File: doc/BRIEF.md
# Load Disambiguation and Blocking Unit

This unit decides, for every load that reaches the memory check step, whether the load may read the data cache, must take its data straight from an older store, or has to wait. It compares the load address against every store-buffer entry that is older than the load and is still allocated. Store IDs are handed out in program order, and each load carries a colour: the ID of the youngest store that precedes it. Only entries whose ID is at or below that colour take part in the comparison.

A load that cannot proceed is parked in a small internal table along with a two-bit reason and the ID of the store that holds it back. Wake-up pulses from the store side announce that a store address or a store's data has just been written. A parked load whose reason matches such a pulse becomes eligible and is sent through the check step again with its saved address and colour, without going back through address generation. A load can be parked several times. Every reason it collects is reported with its final result. Each cycle the unit checks one load. A newly dispatched load takes that slot first, and a parked load fills it only when no new load arrives.

Top module: `load_block_unit`

## Requirements
- R1: Only store entries that are allocated (`sb_busy` set) and whose index, which is the store ID, is less than or equal to the load's colour take part in the check. Other entries do not affect the result.
- R2: If any participating store has an unknown address (`sb_addr_ok` clear), the result is block code 1. This holds even when another store matches or a match lacks data. `out_sid` then gives the youngest such store.
- R3: If every participating address is known and the youngest store whose address equals the load address has no data yet (`sb_data_ok` clear), the result is block code 2, with `out_sid` set to that store.
- R4: If every participating address is known and the youngest matching store has data, `out_fwd` is set and `out_data` carries that store's data. `out_cache_rd` stays clear and `out_sid` names that store.
- R5: If every participating address is known and none equals the load address, including the case where no store participates, `out_cache_rd` is set.
- R6: The result appears on the outputs one clock after the load is checked. Exactly one of `out_fwd`, `out_cache_rd` or a nonzero `out_code` is active with `out_valid`. `out_code` is 0 for none, 1 for an unknown address and 2 for data not ready.
- R7: A blocked load is held in the table. It is released only by a wake-up of the matching kind for its blocking store ID: `wk_addr_en` for code 1, `wk_data_en` for code 2. It is then re-checked with its saved load ID, colour and address, and the result is marked with `out_replay`.
- R8: `out_hist` accumulates every block code the load has received, including the current one. Bit 0 records code 1 and bit 1 records code 2.
- R9: A newly dispatched load (`ld_valid`) is checked before any parked load. When several parked loads are eligible, one is re-checked per cycle, the one with the smallest load ID first.
- R10: A matching wake-up that arrives in the same cycle as the check that blocks a load still releases that load.
- R11: While reset is low, `out_valid` is low on the next clock and the table is emptied, so no parked load is re-checked after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ld_valid | input | 1 | New load present this cycle |
| ld_lid | input | LID_W | Load ID of the new load |
| ld_color | input | SID_W | ID of the youngest older store |
| ld_addr | input | ADDR_W | Load address |
| sb_busy | input | SB_DEPTH | Store entry allocated, indexed by store ID |
| sb_addr_ok | input | SB_DEPTH | Store address known |
| sb_addr | input | SB_DEPTH*ADDR_W | Store addresses, entry i at bits [i*ADDR_W +: ADDR_W] |
| sb_data_ok | input | SB_DEPTH | Store data written |
| sb_data | input | SB_DEPTH*DATA_W | Store data, entry i at bits [i*DATA_W +: DATA_W] |
| wk_addr_en | input | 1 | A store address was just written |
| wk_addr_sid | input | SID_W | Store ID of that address write |
| wk_data_en | input | 1 | A store's data was just written |
| wk_data_sid | input | SID_W | Store ID of that data write |
| out_valid | output | 1 | Check result valid |
| out_lid | output | LID_W | Load ID of the result |
| out_replay | output | 1 | Result belongs to a re-checked load |
| out_fwd | output | 1 | Take data from a store |
| out_data | output | DATA_W | Forwarded data |
| out_cache_rd | output | 1 | Read the data cache |
| out_code | output | 2 | Block code: 0 none, 1 address unknown, 2 data not ready |
| out_sid | output | SID_W | Blocking or forwarding store ID |
| out_hist | output | 2 | Block codes received so far |

## Verification
The bench targets cases where more than one store is relevant at once. It sets up several stores at the same address, where a design that scans in the wrong direction forwards stale data from an older store. It also places an unknown-address store younger than the load's colour, which a design that ignores the colour would block on. A third case pairs an unknown address with a ready match, where a design with the priorities inverted would forward too early.

On the replay path it sends wake-ups of the wrong kind or for the wrong store, which a careless design would treat as a release. It also checks a load that is blocked twice and must report both codes. It sends a wake-up in the same cycle as the blocking check; a design that misses it leaves the load parked forever. Finally, two parked loads become eligible while a new load arrives, which exposes both the arbitration order and the precedence of the new load.

// File: rtl/ldg_pkg.sv
// Shared types for the load blocking unit.
package ldg_pkg;
    // Block reasons; the encoding doubles as the history bit mask.
    typedef enum logic [1:0] {
        BLK_NONE = 2'd0,
        BLK_ADDR = 2'd1,
        BLK_DATA = 2'd2
    } blk_e;
endpackage

// File: rtl/ldg_scan.sv
// Combinational comparison of one load against the older stores.
// Assumes store IDs equal entry indices and do not wrap within the
// window covered by a load's colour.
module ldg_scan
    import ldg_pkg::*;
#(
    parameter int SB_DEPTH = 8,
    parameter int SID_W    = 3,
    parameter int ADDR_W   = 16,
    parameter int DATA_W   = 32
) (
    input  logic [SID_W-1:0]           color,
    input  logic [ADDR_W-1:0]          addr,
    input  logic [SB_DEPTH-1:0]        busy,
    input  logic [SB_DEPTH-1:0]        aok,
    input  logic [SB_DEPTH*ADDR_W-1:0] a_flat,
    input  logic [SB_DEPTH-1:0]        dok,
    input  logic [SB_DEPTH*DATA_W-1:0] d_flat,
    output blk_e                       code,
    output logic [SID_W-1:0]           sid,
    output logic                       fwd,
    output logic [DATA_W-1:0]          fwd_data,
    output logic                       cache_rd
);
    logic [SB_DEPTH-1:0] unk;
    logic [SB_DEPTH-1:0] hit;

    // Per-entry relevance, unknown-address and address-match flags.
    for (genvar i = 0; i < SB_DEPTH; i++) begin : g_ent
        logic rel;
        assign rel    = busy[i] && (i <= int'(color));
        assign unk[i] = rel && !aok[i];
        assign hit[i] = rel && aok[i] && (a_flat[i*ADDR_W +: ADDR_W] == addr);
    end

    logic             unk_any, hit_any;
    logic [SID_W-1:0] unk_sid, hit_sid;

    // Youngest unknown and youngest match: ascending scan keeps the last one.
    always_comb begin
        unk_any = 1'b0;
        hit_any = 1'b0;
        unk_sid = '0;
        hit_sid = '0;
        for (int i = 0; i < SB_DEPTH; i++) begin
            if (unk[i]) begin
                unk_any = 1'b1;
                unk_sid = SID_W'(i);
            end
            if (hit[i]) begin
                hit_any = 1'b1;
                hit_sid = SID_W'(i);
            end
        end
    end

    // Outcome with unknown address ranked above data-not-ready.
    always_comb begin
        code     = BLK_NONE;
        sid      = hit_sid;
        fwd      = 1'b0;
        cache_rd = 1'b0;
        fwd_data = d_flat[int'(hit_sid)*DATA_W +: DATA_W];
        if (unk_any) begin
            code = BLK_ADDR;
            sid  = unk_sid;
        end else if (hit_any && !dok[hit_sid]) begin
            code = BLK_DATA;
        end else if (hit_any) begin
            fwd = 1'b1;
        end else begin
            cache_rd = 1'b1;
        end
    end
endmodule

// File: rtl/ldg_table.sv
// Table of parked loads with wake-up tracking and oldest-first selection.
// Assumes the caller never asks for an insert and a replay update in the
// same cycle, and that the table has room whenever a new load blocks.
module ldg_table
    import ldg_pkg::*;
#(
    parameter int LT_DEPTH = 4,
    parameter int LID_W    = 4,
    parameter int SID_W    = 3,
    parameter int ADDR_W   = 16,
    localparam int SLOT_W  = (LT_DEPTH > 1) ? $clog2(LT_DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ins_en,
    input  logic [LID_W-1:0]  ins_lid,
    input  logic [SID_W-1:0]  ins_color,
    input  logic [ADDR_W-1:0] ins_addr,
    input  blk_e              ins_code,
    input  logic [SID_W-1:0]  ins_sid,
    input  logic              rp_take,
    input  blk_e              upd_code,
    input  logic [SID_W-1:0]  upd_sid,
    input  logic              wk_addr_en,
    input  logic [SID_W-1:0]  wk_addr_sid,
    input  logic              wk_data_en,
    input  logic [SID_W-1:0]  wk_data_sid,
    output logic              rp_valid,
    output logic [LID_W-1:0]  rp_lid,
    output logic [SID_W-1:0]  rp_color,
    output logic [ADDR_W-1:0] rp_addr,
    output logic [1:0]        rp_hist,
    output logic              full
);
    logic [LT_DEPTH-1:0] vld, rdy;
    logic [LID_W-1:0]    t_lid   [LT_DEPTH];
    logic [SID_W-1:0]    t_color [LT_DEPTH];
    logic [ADDR_W-1:0]   t_addr  [LT_DEPTH];
    blk_e                t_code  [LT_DEPTH];
    logic [SID_W-1:0]    t_sid   [LT_DEPTH];
    logic [1:0]          t_hist  [LT_DEPTH];
    logic [SLOT_W-1:0]   rp_slot, free_slot;

    // True when a wake-up this cycle clears the given block reason.
    function automatic logic woken(blk_e c, logic [SID_W-1:0] s);
        return (c == BLK_ADDR && wk_addr_en && wk_addr_sid == s) ||
               (c == BLK_DATA && wk_data_en && wk_data_sid == s);
    endfunction

    // First free slot and the full flag.
    always_comb begin
        full      = 1'b1;
        free_slot = '0;
        for (int k = 0; k < LT_DEPTH; k++) begin
            if (!vld[k] && full) begin
                full      = 1'b0;
                free_slot = SLOT_W'(k);
            end
        end
    end

    // Eligible entry with the smallest load ID.
    always_comb begin
        logic [LID_W-1:0] best;
        best     = '0;
        rp_valid = 1'b0;
        rp_slot  = '0;
        for (int k = 0; k < LT_DEPTH; k++) begin
            if (vld[k] && rdy[k] && (!rp_valid || t_lid[k] < best)) begin
                rp_valid = 1'b1;
                rp_slot  = SLOT_W'(k);
                best     = t_lid[k];
            end
        end
    end

    assign rp_lid   = t_lid[rp_slot];
    assign rp_color = t_color[rp_slot];
    assign rp_addr  = t_addr[rp_slot];
    assign rp_hist  = t_hist[rp_slot];

    // Entry state: wake-ups, replay write-back and new inserts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld <= '0;
            rdy <= '0;
            for (int k = 0; k < LT_DEPTH; k++) begin
                t_lid[k]   <= '0;
                t_color[k] <= '0;
                t_addr[k]  <= '0;
                t_code[k]  <= BLK_NONE;
                t_sid[k]   <= '0;
                t_hist[k]  <= '0;
            end
        end else begin
            for (int k = 0; k < LT_DEPTH; k++) begin
                if (vld[k] && woken(t_code[k], t_sid[k])) rdy[k] <= 1'b1;
            end
            if (rp_take) begin
                if (upd_code != BLK_NONE) begin
                    t_code[rp_slot] <= upd_code;
                    t_sid[rp_slot]  <= upd_sid;
                    t_hist[rp_slot] <= t_hist[rp_slot] | upd_code;
                    rdy[rp_slot]    <= woken(upd_code, upd_sid);
                end else begin
                    vld[rp_slot] <= 1'b0;
                    rdy[rp_slot] <= 1'b0;
                end
            end
            if (ins_en && !full) begin
                vld[free_slot]     <= 1'b1;
                rdy[free_slot]     <= woken(ins_code, ins_sid);
                t_lid[free_slot]   <= ins_lid;
                t_color[free_slot] <= ins_color;
                t_addr[free_slot]  <= ins_addr;
                t_code[free_slot]  <= ins_code;
                t_sid[free_slot]   <= ins_sid;
                t_hist[free_slot]  <= ins_code;
            end
        end
    end
endmodule

// File: rtl/load_block_unit.sv
// Memory check step for loads: picks a new or parked load, compares it with
// the older stores and registers the outcome. New loads take the check slot
// first; parked loads re-enter here without address generation.
module load_block_unit
    import ldg_pkg::*;
#(
    parameter int SB_DEPTH = 8,
    parameter int ADDR_W   = 16,
    parameter int DATA_W   = 32,
    parameter int LID_W    = 4,
    parameter int LT_DEPTH = 4,
    localparam int SID_W   = $clog2(SB_DEPTH)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       ld_valid,
    input  logic [LID_W-1:0]           ld_lid,
    input  logic [SID_W-1:0]           ld_color,
    input  logic [ADDR_W-1:0]          ld_addr,
    input  logic [SB_DEPTH-1:0]        sb_busy,
    input  logic [SB_DEPTH-1:0]        sb_addr_ok,
    input  logic [SB_DEPTH*ADDR_W-1:0] sb_addr,
    input  logic [SB_DEPTH-1:0]        sb_data_ok,
    input  logic [SB_DEPTH*DATA_W-1:0] sb_data,
    input  logic                       wk_addr_en,
    input  logic [SID_W-1:0]           wk_addr_sid,
    input  logic                       wk_data_en,
    input  logic [SID_W-1:0]           wk_data_sid,
    output logic                       out_valid,
    output logic [LID_W-1:0]           out_lid,
    output logic                       out_replay,
    output logic                       out_fwd,
    output logic [DATA_W-1:0]          out_data,
    output logic                       out_cache_rd,
    output logic [1:0]                 out_code,
    output logic [SID_W-1:0]           out_sid,
    output logic [1:0]                 out_hist
);
    logic              rp_valid, rp_take, chk_valid, tbl_full, tbl_ins;
    logic [LID_W-1:0]  rp_lid, chk_lid;
    logic [SID_W-1:0]  rp_color, chk_color, s_sid;
    logic [ADDR_W-1:0] rp_addr, chk_addr;
    logic [1:0]        rp_hist, chk_hist;
    blk_e              s_code;
    logic              s_fwd, s_cache;
    logic [DATA_W-1:0] s_data;

    // Check-slot arbitration: a new load wins over a parked one.
    assign rp_take   = rp_valid && !ld_valid;
    assign chk_valid = ld_valid || rp_take;
    assign chk_lid   = ld_valid ? ld_lid   : rp_lid;
    assign chk_color = ld_valid ? ld_color : rp_color;
    assign chk_addr  = ld_valid ? ld_addr  : rp_addr;
    assign chk_hist  = ld_valid ? 2'b00    : rp_hist;
    assign tbl_ins   = ld_valid && (s_code != BLK_NONE);

    ldg_scan #(
        .SB_DEPTH(SB_DEPTH), .SID_W(SID_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
    ) u_scan (
        .color(chk_color), .addr(chk_addr), .busy(sb_busy), .aok(sb_addr_ok),
        .a_flat(sb_addr), .dok(sb_data_ok), .d_flat(sb_data),
        .code(s_code), .sid(s_sid), .fwd(s_fwd), .fwd_data(s_data),
        .cache_rd(s_cache)
    );

    ldg_table #(
        .LT_DEPTH(LT_DEPTH), .LID_W(LID_W), .SID_W(SID_W), .ADDR_W(ADDR_W)
    ) u_table (
        .clk(clk), .rst_n(rst_n),
        .ins_en(tbl_ins), .ins_lid(ld_lid), .ins_color(ld_color),
        .ins_addr(ld_addr), .ins_code(s_code), .ins_sid(s_sid),
        .rp_take(rp_take), .upd_code(s_code), .upd_sid(s_sid),
        .wk_addr_en(wk_addr_en), .wk_addr_sid(wk_addr_sid),
        .wk_data_en(wk_data_en), .wk_data_sid(wk_data_sid),
        .rp_valid(rp_valid), .rp_lid(rp_lid), .rp_color(rp_color),
        .rp_addr(rp_addr), .rp_hist(rp_hist), .full(tbl_full)
    );

    // Result register: one cycle after the check.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid    <= 1'b0;
            out_lid      <= '0;
            out_replay   <= 1'b0;
            out_fwd      <= 1'b0;
            out_data     <= '0;
            out_cache_rd <= 1'b0;
            out_code     <= 2'd0;
            out_sid      <= '0;
            out_hist     <= 2'd0;
        end else begin
            out_valid    <= chk_valid;
            out_lid      <= chk_lid;
            out_replay   <= rp_take;
            out_fwd      <= chk_valid && s_fwd;
            out_data     <= s_data;
            out_cache_rd <= chk_valid && s_cache;
            out_code     <= chk_valid ? s_code : BLK_NONE;
            out_sid      <= s_sid;
            out_hist     <= chk_hist | s_code;
        end
    end
endmodule

// File: rtl/ldg_chk.sv
// Property checker for load_block_unit, attached by bind below.
module ldg_chk #(
    parameter int LID_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ld_valid,
    input logic [LID_W-1:0] ld_lid,
    input logic             out_valid,
    input logic [LID_W-1:0] out_lid,
    input logic             out_replay,
    input logic             out_fwd,
    input logic             out_cache_rd,
    input logic [1:0]       out_code,
    input logic [1:0]       out_hist,
    input logic             tbl_ins,
    input logic             tbl_full
);
    // R6
    one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $countones({out_fwd, out_cache_rd, out_code != 2'd0}) == 1);
    // R6
    code_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_code != 2'd3);
    // R6
    new_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_replay) |-> ($past(ld_valid) && out_lid == $past(ld_lid)));
    // R9
    replay_yield_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_replay |-> !$past(ld_valid));
    // R8
    hist_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_code == 2'd1) |-> out_hist[0]);
    // R8
    hist_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_code == 2'd2) |-> out_hist[1]);
    // R7
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tbl_ins |-> !tbl_full);
    // R11
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> !out_valid);
endmodule

bind load_block_unit ldg_chk #(.LID_W(LID_W)) u_ldg_chk (
    .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_lid(ld_lid),
    .out_valid(out_valid), .out_lid(out_lid), .out_replay(out_replay),
    .out_fwd(out_fwd), .out_cache_rd(out_cache_rd), .out_code(out_code),
    .out_hist(out_hist), .tbl_ins(tbl_ins), .tbl_full(tbl_full)
);

// File: tb/test_load_block_unit.sv
`timescale 1ns/1ps
module test_load_block_unit;
    localparam int N = 8, AW = 16, DW = 32, LW = 4, SW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ld_valid = 1'b0;
    logic [LW-1:0] ld_lid = '0;
    logic [SW-1:0] ld_color = '0;
    logic [AW-1:0] ld_addr = '0;
    logic [N-1:0]  sb_busy = '0, sb_addr_ok = '0, sb_data_ok = '0;
    logic [N*AW-1:0] sb_addr;
    logic [N*DW-1:0] sb_data;
    logic          wk_addr_en = 1'b0, wk_data_en = 1'b0;
    logic [SW-1:0] wk_addr_sid = '0, wk_data_sid = '0;
    logic          out_valid, out_replay, out_fwd, out_cache_rd;
    logic [LW-1:0] out_lid;
    logic [DW-1:0] out_data;
    logic [1:0]    out_code, out_hist;
    logic [SW-1:0] out_sid;
    int total = 0, bad = 0;

    always #2 clk = ~clk;

    load_block_unit i_load_block_unit (
        .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_lid(ld_lid),
        .ld_color(ld_color), .ld_addr(ld_addr), .sb_busy(sb_busy),
        .sb_addr_ok(sb_addr_ok), .sb_addr(sb_addr), .sb_data_ok(sb_data_ok),
        .sb_data(sb_data), .wk_addr_en(wk_addr_en), .wk_addr_sid(wk_addr_sid),
        .wk_data_en(wk_data_en), .wk_data_sid(wk_data_sid),
        .out_valid(out_valid), .out_lid(out_lid), .out_replay(out_replay),
        .out_fwd(out_fwd), .out_data(out_data), .out_cache_rd(out_cache_rd),
        .out_code(out_code), .out_sid(out_sid), .out_hist(out_hist)
    );

    // kind: 0 cache read, 1 block addr, 2 block data, 3 forward
    typedef struct packed {
        logic [7:0]  busy, aok, dok;
        logic [2:0]  col;
        logic [15:0] addr;
        logic [1:0]  kind;
        logic [2:0]  sid;
    } vec_t;

    // Store entry i: address 0x40 when i is even, else 0x80+i; data 0xD000+i.
    localparam vec_t VECS [10] = '{
        '{8'hff, 8'hff, 8'hff, 3'd7, 16'h0040, 2'd3, 3'd6}, // R4 youngest match
        '{8'hff, 8'hff, 8'hff, 3'd5, 16'h0040, 2'd3, 3'd4}, // R1 colour limit
        '{8'hff, 8'hff, 8'hff, 3'd7, 16'h0050, 2'd0, 3'd0}, // R5 no match
        '{8'hff, 8'hdf, 8'hff, 3'd7, 16'h0040, 2'd1, 3'd5}, // R2 beats a match
        '{8'hff, 8'hdf, 8'hff, 3'd4, 16'h0040, 2'd3, 3'd4}, // R1 younger unknown ignored
        '{8'hff, 8'hff, 8'hbf, 3'd7, 16'h0040, 2'd2, 3'd6}, // R3 youngest lacks data
        '{8'hff, 8'hff, 8'hbf, 3'd7, 16'h0085, 2'd3, 3'd5}, // R4 single match
        '{8'h00, 8'hff, 8'hff, 3'd7, 16'h0040, 2'd0, 3'd0}, // R5 nothing allocated
        '{8'hff, 8'hf5, 8'hff, 3'd7, 16'h0050, 2'd1, 3'd3}, // R2 youngest unknown
        '{8'h0f, 8'h0f, 8'hff, 3'd7, 16'h0040, 2'd3, 3'd2}  // R1 idle entries ignored
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; ld_valid = 1'b0; wk_addr_en = 1'b0; wk_data_en = 1'b0;
        tick(); tick();
        check("R11 out_valid in reset", 32'(out_valid), 32'd0);
        rst_n = 1'b1;
    endtask

    task automatic load(input logic [3:0] lid, input logic [2:0] col, input logic [15:0] a);
        ld_valid = 1'b1; ld_lid = lid; ld_color = col; ld_addr = a;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        bad++;
        $display("FAIL R6 watchdog act=hung exp=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < N; i++) begin
            sb_addr[i*AW +: AW] = (i % 2 == 0) ? 16'h0040 : 16'(16'h0080 + i);
            sb_data[i*DW +: DW] = 32'(32'hD000 + i);
        end
        tick();
        do_reset();
        tick();
        check("R11 idle after reset", 32'(out_valid), 32'd0);

        // Vector table walk
        for (int v = 0; v < 10; v++) begin
            logic [1:0] k;
            string tag;
            sb_busy = VECS[v].busy; sb_addr_ok = VECS[v].aok; sb_data_ok = VECS[v].dok;
            load(4'(v), VECS[v].col, VECS[v].addr);
            tick();
            ld_valid = 1'b0;
            k = (out_code != 2'd0) ? out_code : (out_fwd ? 2'd3 : 2'd0);
            case (VECS[v].kind)
                2'd1: tag = $sformatf("R2 vec%0d kind", v);
                2'd2: tag = $sformatf("R3 vec%0d kind", v);
                2'd3: tag = $sformatf("R4 vec%0d kind", v);
                default: tag = $sformatf("R5 vec%0d kind", v);
            endcase
            check(tag, 32'(k), 32'(VECS[v].kind));
            check($sformatf("R6 vec%0d valid", v), 32'(out_valid), 32'd1);
            check($sformatf("R5 vec%0d cache_rd", v), 32'(out_cache_rd), 32'(VECS[v].kind == 2'd0));
            if (VECS[v].kind != 2'd0)
                check($sformatf("R2 vec%0d sid", v), 32'(out_sid), 32'(VECS[v].sid));
            if (VECS[v].kind == 2'd3)
                check($sformatf("R4 vec%0d data", v), out_data, 32'(32'hD000 + VECS[v].sid));
        end

        // R7 R8: blocked twice, wrong wake-ups ignored
        do_reset();
        sb_busy = 8'h03; sb_addr_ok = 8'h01; sb_data_ok = 8'h01;
        load(4'd5, 3'd1, 16'h0081);
        tick();
        ld_valid = 1'b0;
        check("R2 first block code", 32'(out_code), 32'd1);
        wk_data_en = 1'b1; wk_data_sid = 3'd1; wk_addr_en = 1'b1; wk_addr_sid = 3'd0;
        tick();
        wk_data_en = 1'b0; wk_addr_en = 1'b0;
        check("R7 wrong wake no replay a", 32'(out_valid), 32'd0);
        tick();
        check("R7 wrong wake no replay b", 32'(out_valid), 32'd0);
        wk_addr_en = 1'b1; wk_addr_sid = 3'd1; sb_addr_ok = 8'h03;
        tick();
        wk_addr_en = 1'b0;
        check("R7 no replay before ready", 32'(out_valid), 32'd0);
        tick();
        check("R7 replay flag", 32'(out_replay), 32'd1);
        check("R7 replay lid", 32'(out_lid), 32'd5);
        check("R3 second block code", 32'(out_code), 32'd2);
        check("R8 history two codes", 32'(out_hist), 32'd3);
        wk_data_en = 1'b1; wk_data_sid = 3'd1; sb_data_ok = 8'h03;
        tick();
        wk_data_en = 1'b0;
        tick();
        check("R4 replay forward", 32'(out_fwd), 32'd1);
        check("R4 replay data", out_data, 32'hD001);
        check("R8 history kept", 32'(out_hist), 32'd3);

        // R10: wake-up in the same cycle as the block
        do_reset();
        sb_busy = 8'h01; sb_addr_ok = 8'h00; sb_data_ok = 8'h01;
        load(4'd2, 3'd0, 16'h0040);
        wk_addr_en = 1'b1; wk_addr_sid = 3'd0;
        tick();
        ld_valid = 1'b0; wk_addr_en = 1'b0; sb_addr_ok = 8'h01;
        check("R10 blocked first", 32'(out_code), 32'd1);
        tick();
        check("R10 released replay", 32'(out_replay && out_lid == 4'd2), 32'd1);
        check("R10 forwarded", 32'(out_fwd), 32'd1);

        // R9: new load first, then oldest parked load
        do_reset();
        sb_busy = 8'h01; sb_addr_ok = 8'h00; sb_data_ok = 8'h01;
        load(4'd7, 3'd0, 16'h0040);
        tick();
        load(4'd3, 3'd0, 16'h0040);
        check("R2 lid7 blocked", 32'(out_code), 32'd1);
        tick();
        ld_valid = 1'b0;
        check("R2 lid3 blocked", 32'(out_code), 32'd1);
        wk_addr_en = 1'b1; wk_addr_sid = 3'd0; sb_addr_ok = 8'h01;
        tick();
        wk_addr_en = 1'b0;
        load(4'd9, 3'd0, 16'h0099);
        tick();
        ld_valid = 1'b0;
        check("R9 new load first", 32'({out_replay, out_lid}), 32'({1'b0, 4'd9}));
        check("R5 new load cache", 32'(out_cache_rd), 32'd1);
        tick();
        check("R9 oldest replay first", 32'({out_replay, out_lid}), 32'({1'b1, 4'd3}));
        tick();
        check("R9 second replay", 32'({out_replay, out_lid}), 32'({1'b1, 4'd7}));
        tick();
        check("R9 table drained", 32'(out_valid), 32'd0);

        // R11: parked load dropped by reset
        sb_addr_ok = 8'h00;
        load(4'd1, 3'd0, 16'h0040);
        tick();
        ld_valid = 1'b0;
        do_reset();
        wk_addr_en = 1'b1; wk_addr_sid = 3'd0; sb_addr_ok = 8'h01;
        tick();
        wk_addr_en = 1'b0;
        tick(); tick();
        check("R11 no replay after reset", 32'(out_valid), 32'd0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule